// File: doc/BRIEF.md
# Pausable Twelve-Hour Time-of-Day Counter

This block keeps the wall-clock time as four chained counters: hundredths of a second, seconds, minutes and hours. It uses a twelve-hour format with a separate afternoon flag. A one-cycle tick at 100 Hz, generated elsewhere, advances the hundredths counter. Each higher counter steps when the counter below it wraps. The carry runs through all four levels within the same clock edge.

An edit controller sits beside the block. It can stop the clock with a freeze request, and it can zero the sub-minute part with a clear request so the time restarts cleanly. It can overwrite the hour, the minute and the afternoon flag through a load strobe, and it can flip the afternoon flag directly. A global run enable pauses the time. A synchronous clear and an asynchronous active-low reset both return the time to midnight. All outputs are plain binary values taken straight from registers.

Top module: `tod_counter`

## Requirements
- R1: Hundredths count 0..99. The counter steps by one on each qualifying edge, meaning `tick` high, `run_en` high and `freeze` low. From 99 it wraps to 0, and its carry is high for exactly that one cycle.
- R2: Seconds count 0..59 and minutes count 0..59. Each steps only in the cycle where the counter below it wraps. The step shows on the same clock edge as the lower counter's wrap.
- R3: The hour sequence is 12, 1, 2, … 11, 12. The hour is never 0 and never above 12. The flag `pm` (1 = afternoon) flips when the hour steps from 11 to 12 and at no other step.
- R4: While `run_en` is low, hundredths, seconds, minutes and hours keep their values whatever `tick` does. Counting resumes from those values.
- R5: While `freeze` is high, the time does not advance. Load, toggle and the clears still take effect during freeze.
- R6: A `clr_subsec` pulse sets seconds and hundredths to 0 on the next edge, even if a tick arrives in the same cycle. That cycle produces no carry into the minutes.
- R7: `pm_toggle` flips `pm` on the next edge. If an 11→12 step happens on the same edge, the two flips cancel.
- R8: `load` replaces hour, minute and `pm` with `load_hour`, `load_min` and `load_pm` on the next edge. The load takes precedence over any carry and any toggle. A loaded hour of 0 or 13..15 becomes 12, and a loaded minute of 60..63 becomes 0.
- R9: `clr` sets the time to 12:00:00.00 with `pm` = 0 on the next edge. It takes precedence over every other input.
- R10: While `rst_n` is low, the time reads 12:00:00.00 with `pm` = 0. Reset takes effect asynchronously, and its release is synchronised to the clock over two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to midnight |
| run_en | input | 1 | Global run enable |
| tick | input | 1 | 100 Hz one-cycle advance pulse |
| freeze | input | 1 | Hold request from the edit controller |
| clr_subsec | input | 1 | Zero seconds and hundredths |
| pm_toggle | input | 1 | Flip the afternoon flag |
| load | input | 1 | Load hour, minute and flag |
| load_hour | input | 4 | Hour value to load (1..12) |
| load_min | input | 6 | Minute value to load (0..59) |
| load_pm | input | 1 | Afternoon flag to load |
| hour | output | 4 | Current hour, 1..12 |
| minute | output | 6 | Current minute |
| second | output | 6 | Current second |
| centi | output | 7 | Current hundredths of a second |
| pm | output | 1 | Afternoon flag |

## Verification
Several properties are checked on every cycle:
- every field stays within its legal range;
- each carry lasts exactly one cycle and leaves its counter at zero;
- a paused or frozen clock keeps its sub-minute fields steady;
- the clears and the load land on the next edge;
- the 11→12 step flips the flag.

Some behaviours are shown only by the bench's scenarios, which compare every cycle against a behavioural model. These are:
- the full carry ripple through the minute and hour boundaries;
- the cancelling of a toggle against a rollover;
- the clamping of illegal load values;
- the way the two-edge reset release interacts with the first count.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int unsigned TOD_CS_PER_SEC  = 100;
  localparam int unsigned TOD_SEC_PER_MIN = 60;
  localparam int unsigned TOD_MIN_PER_HR  = 60;
  localparam int unsigned TOD_HR_PER_HALF = 12;

  // Legal hour test for a twelve-hour counter: 1..half.
  function automatic logic tod_hour_ok(input int unsigned h, input int unsigned half);
    return (h >= 1) && (h <= half);
  endfunction

endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/tod_wrap_cnt.sv
module tod_wrap_cnt #(
  parameter int unsigned MOD = 60,
  localparam int unsigned W = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         ovf
);

  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         at_top;
  logic         upd;

  assign at_top = (val_q == TOP);
  assign ovf    = inc && at_top && !clr && !ld;

  always_comb begin
    val_d = val_q;
    if (clr) begin
      val_d = '0;
    end else if (ld) begin
      val_d = ld_val;
    end else if (inc) begin
      val_d = at_top ? '0 : val_q + W'(1);
    end
  end

  assign upd = clr || ld || inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (upd) begin
      val_q <= val_d;
    end
  end

  assign val = val_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(val_q) < MOD); // R1
  AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf); // R1
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (val_q == '0)); // R2

endmodule

// File: rtl/tod_hour_cnt.sv
module tod_hour_cnt
  import tod_pkg::*;
#(
  parameter int unsigned HALF = TOD_HR_PER_HALF,
  localparam int unsigned W = $clog2(HALF + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_hour,
  input  logic         ld_pm,
  input  logic         toggle,
  output logic [W-1:0] hour,
  output logic         pm
);

  localparam logic [W-1:0] TOP_HR  = W'(HALF);
  localparam logic [W-1:0] FLIP_HR = W'(HALF - 1);

  logic [W-1:0] hour_q, hour_d;
  logic         pm_q, pm_d;
  logic         ld_ok;
  logic         upd;

  assign ld_ok = tod_hour_ok(32'(ld_hour), HALF);

  always_comb begin
    hour_d = hour_q;
    pm_d   = pm_q;
    if (clr) begin
      hour_d = TOP_HR;
      pm_d   = 1'b0;
    end else if (ld) begin
      hour_d = ld_ok ? ld_hour : TOP_HR;
      pm_d   = ld_pm;
    end else begin
      if (inc) begin
        hour_d = (hour_q == TOP_HR) ? W'(1) : hour_q + W'(1);
      end
      pm_d = pm_q ^ toggle ^ (inc && (hour_q == FLIP_HR));
    end
  end

  assign upd = clr || ld || inc || toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hour_q <= TOP_HR;
      pm_q   <= 1'b0;
    end else if (upd) begin
      hour_q <= hour_d;
      pm_q   <= pm_d;
    end
  end

  assign hour = hour_q;
  assign pm   = pm_q;

  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_q != '0) && (32'(hour_q) <= HALF)); // R3
  AST_PM_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld && !toggle && hour_q == FLIP_HR)
      |=> (hour_q == TOP_HR) && (pm_q != $past(pm_q))); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !clr && !ld && !inc) |=> (pm_q != $past(pm_q))); // R7
  AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (pm_q == $past(ld_pm))); // R8

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned CS_MOD     = TOD_CS_PER_SEC,
  parameter int unsigned SEC_MOD    = TOD_SEC_PER_MIN,
  parameter int unsigned MIN_MOD    = TOD_MIN_PER_HR,
  parameter int unsigned HALF_DAY   = TOD_HR_PER_HALF,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned CS_W  = $clog2(CS_MOD),
  localparam int unsigned SEC_W = $clog2(SEC_MOD),
  localparam int unsigned MIN_W = $clog2(MIN_MOD),
  localparam int unsigned HR_W  = $clog2(HALF_DAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run_en,
  input  logic             tick,
  input  logic             freeze,
  input  logic             clr_subsec,
  input  logic             pm_toggle,
  input  logic             load,
  input  logic [HR_W-1:0]  load_hour,
  input  logic [MIN_W-1:0] load_min,
  input  logic             load_pm,
  output logic [HR_W-1:0]  hour,
  output logic [MIN_W-1:0] minute,
  output logic [SEC_W-1:0] second,
  output logic [CS_W-1:0]  centi,
  output logic             pm
);

  logic             rst_sync_n;
  logic             adv;
  logic             sub_clr;
  logic             cs_ovf, sec_ovf, min_ovf;
  logic [MIN_W-1:0] min_ld_val;

  tod_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign adv     = tick && run_en && !freeze;
  assign sub_clr = clr || clr_subsec;

  // A minute value outside the legal range is loaded as zero.
  always_comb begin
    min_ld_val = (32'(load_min) < MIN_MOD) ? load_min : '0;
  end

  tod_wrap_cnt #(.MOD(CS_MOD)) u_cs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (sub_clr),
    .inc    (adv),
    .ld     (1'b0),
    .ld_val ('0),
    .val    (centi),
    .ovf    (cs_ovf)
  );

  tod_wrap_cnt #(.MOD(SEC_MOD)) u_sec (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (sub_clr),
    .inc    (cs_ovf),
    .ld     (1'b0),
    .ld_val ('0),
    .val    (second),
    .ovf    (sec_ovf)
  );

  tod_wrap_cnt #(.MOD(MIN_MOD)) u_min (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (clr),
    .inc    (sec_ovf),
    .ld     (load),
    .ld_val (min_ld_val),
    .val    (minute),
    .ovf    (min_ovf)
  );

  tod_hour_cnt #(.HALF(HALF_DAY)) u_hr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clr),
    .inc     (min_ovf),
    .ld      (load),
    .ld_hour (load_hour),
    .ld_pm   (load_pm),
    .toggle  (pm_toggle),
    .hour    (hour),
    .pm      (pm)
  );

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_en && !sub_clr) |=> $stable(centi) && $stable(second)); // R4
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (freeze && !sub_clr) |=> $stable(centi) && $stable(second)); // R5
  AST_SUBSEC_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_subsec |=> (centi == '0) && (second == '0)); // R6
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (32'(hour) == HALF_DAY) && (minute == '0) && !pm); // R9

endmodule

// File: tb/sim_tod_counter.sv
module sim_tod_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, run_en = 1'b0, tick = 1'b0, freeze = 1'b0;
  logic       clr_subsec = 1'b0, pm_toggle = 1'b0, load = 1'b0, load_pm = 1'b0;
  logic [3:0] load_hour = 4'd0;
  logic [5:0] load_min = 6'd0;
  logic [3:0] hour;
  logic [5:0] minute, second;
  logic [6:0] centi;
  logic       pm;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit done = 0;

  // Reference state
  int mc, ms, mm, mh, mp;
  int nc, ns, nm, nh, np;
  bit adv, co, so, mo;

  always #2.5 clk = ~clk;

  tod_counter u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run_en(run_en), .tick(tick),
    .freeze(freeze), .clr_subsec(clr_subsec), .pm_toggle(pm_toggle),
    .load(load), .load_hour(load_hour), .load_min(load_min), .load_pm(load_pm),
    .hour(hour), .minute(minute), .second(second), .centi(centi), .pm(pm)
  );

  // Behavioural model of the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = 0; ms = 0; mm = 0; mh = 12; mp = 0;
    end else if (clr) begin
      mc = 0; ms = 0; mm = 0; mh = 12; mp = 0;          // R9
    end else begin
      adv = tick && run_en && !freeze;
      co  = adv && (mc == 99) && !clr_subsec;
      so  = co && (ms == 59);
      mo  = so && (mm == 59);
      nc = clr_subsec ? 0 : (adv ? (mc + 1) % 100 : mc);
      ns = clr_subsec ? 0 : (co ? (ms + 1) % 60 : ms);
      if (load) begin
        nm = (load_min > 59) ? 0 : int'(load_min);
        nh = (load_hour == 0 || load_hour > 12) ? 12 : int'(load_hour);
        np = int'(load_pm);
      end else begin
        nm = so ? (mm + 1) % 60 : mm;
        nh = mo ? ((mh == 12) ? 1 : mh + 1) : mh;
        np = mp ^ int'(pm_toggle) ^ int'(mo && mh == 11);
      end
      mc = nc; ms = ns; mm = nm; mh = nh; mp = np;
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(centi) != mc || int'(second) != ms || int'(minute) != mm ||
          int'(hour) != mh || int'(pm) != mp) begin
        errors++;
        $display("FAIL %s: got %0d:%0d:%0d.%0d pm=%0d exp %0d:%0d:%0d.%0d pm=%0d",
                 cur_req, hour, minute, second, centi, pm, mh, mm, ms, mc, mp);
      end
    end
  end

  task automatic expect_time(input string req, input int h, input int m,
                             input int s, input int c, input int p);
    checks++;
    if (int'(hour) != h || int'(minute) != m || int'(second) != s ||
        int'(centi) != c || int'(pm) != p) begin
      errors++;
      $display("FAIL %s: got %0d:%0d:%0d.%0d pm=%0d exp %0d:%0d:%0d.%0d pm=%0d",
               req, hour, minute, second, centi, pm, h, m, s, c, p);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_load(input int h, input int m, input bit p);
    load_hour = 4'(h); load_min = 6'(m); load_pm = p; load = 1'b1;
    cyc(1);
    load = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    // R10: reset state while held and after release
    cyc(3);
    expect_time("R10", 12, 0, 0, 0, 0);
    rst_n = 1'b1;
    cyc(4);
    expect_time("R10", 12, 0, 0, 0, 0);

    // R1/R2: continuous ticks across hundredths and seconds wraps
    cur_req = "R1";
    run_en = 1'b1; tick = 1'b1;
    cyc(250);
    tick = 1'b0; cyc(1);
    expect_time("R1", 12, 0, 2, 50, 0);

    // R2: sparse ticks, every third cycle
    cur_req = "R2";
    for (int i = 0; i < 450; i++) begin
      tick = (i % 3 == 0); cyc(1);
    end
    tick = 1'b0; cyc(1);
    expect_time("R2", 12, 0, 4, 0, 0);

    // R4: enable low ignores ticks
    cur_req = "R4";
    run_en = 1'b0; tick = 1'b1;
    cyc(60);
    expect_time("R4", 12, 0, 4, 0, 0);
    run_en = 1'b1; cyc(5); tick = 1'b0; cyc(1);
    expect_time("R4", 12, 0, 4, 5, 0);

    // R5: freeze holds, load still applies
    cur_req = "R5";
    freeze = 1'b1; tick = 1'b1;
    cyc(40);
    expect_time("R5", 12, 0, 4, 5, 0);
    do_load(3, 17, 1'b1);
    expect_time("R5", 3, 17, 4, 5, 1);
    freeze = 1'b0; tick = 1'b0; cyc(1);

    // R6: clear sub-minute with a simultaneous tick, and at 59.99
    cur_req = "R6";
    tick = 1'b1; clr_subsec = 1'b1; cyc(1); clr_subsec = 1'b0; tick = 1'b0;
    expect_time("R6", 3, 17, 0, 0, 1);
    tick = 1'b1; cyc(5999); tick = 1'b0; cyc(1);
    expect_time("R6", 3, 17, 59, 99, 1);
    tick = 1'b1; clr_subsec = 1'b1; cyc(1); clr_subsec = 1'b0; tick = 1'b0;
    expect_time("R6", 3, 17, 0, 0, 1);

    // R3: 11:59 -> 12:00 flips the flag; 12:59 -> 1:00 keeps it
    cur_req = "R3";
    do_load(11, 59, 1'b0);
    clr_subsec = 1'b1; cyc(1); clr_subsec = 1'b0;
    tick = 1'b1; cyc(6000); tick = 1'b0; cyc(1);
    expect_time("R3", 12, 0, 0, 0, 1);
    do_load(12, 59, 1'b1);
    clr_subsec = 1'b1; cyc(1); clr_subsec = 1'b0;
    tick = 1'b1; cyc(6000); tick = 1'b0; cyc(1);
    expect_time("R3", 1, 0, 0, 0, 1);

    // R7: toggle alone, then toggle on the 11 -> 12 edge cancels
    cur_req = "R7";
    pm_toggle = 1'b1; cyc(1); pm_toggle = 1'b0;
    expect_time("R7", 1, 0, 0, 0, 0);
    do_load(11, 59, 1'b0);
    clr_subsec = 1'b1; cyc(1); clr_subsec = 1'b0;
    tick = 1'b1; cyc(5999);
    pm_toggle = 1'b1; cyc(1); pm_toggle = 1'b0; tick = 1'b0; cyc(1);
    expect_time("R7", 12, 0, 0, 0, 0);

    // R8: illegal load values clamp; load beats a carry
    cur_req = "R8";
    do_load(0, 60, 1'b1);
    expect_time("R8", 12, 0, 0, 0, 1);
    do_load(13, 63, 1'b0);
    expect_time("R8", 12, 0, 0, 0, 0);
    do_load(15, 45, 1'b1);
    expect_time("R8", 12, 45, 0, 0, 1);
    do_load(7, 59, 1'b0);
    tick = 1'b1; cyc(5999);
    load_hour = 4'd9; load_min = 6'd30; load_pm = 1'b1; load = 1'b1; pm_toggle = 1'b1;
    cyc(1);
    load = 1'b0; pm_toggle = 1'b0; tick = 1'b0; cyc(1);
    expect_time("R8", 9, 30, 0, 0, 1);

    // R9: clear wins over load and ticks
    cur_req = "R9";
    tick = 1'b1; cyc(77);
    load_hour = 4'd5; load_min = 6'd5; load = 1'b1; clr = 1'b1; cyc(1);
    load = 1'b0; clr = 1'b0; tick = 1'b0; cyc(1);
    expect_time("R9", 12, 0, 0, 0, 0);

    // R10: asynchronous reset mid-count
    cur_req = "R10";
    tick = 1'b1; cyc(123);
    #1 rst_n = 1'b0; #1;
    expect_time("R10", 12, 0, 0, 0, 0);
    cyc(2); rst_n = 1'b1; tick = 1'b0; cyc(4);
    expect_time("R10", 12, 0, 0, 0, 0);

    finish_run();
  end

endmodule